// File: doc/BRIEF.md
# Sensor Stream Standby Controller

This block decides whether an image sensor's readout engine is producing rows or resting in a low-power standby. Software programs a small control word and two readout dimensions through a write-only register port. A built-in row/column counter paces the readout and emits single-cycle end-of-row and end-of-frame strobes. When software clears the streaming bit, readout is not cut off at once. It keeps running until the next row boundary or frame boundary, as chosen by a mode bit, and then stops cleanly.

While the block is in standby the registers keep their contents, and streaming resumes with the same dimensions. Resumed readout always starts at the first pixel of a new frame. A separate serial-disable bit is passed straight to an output, so software can shut the serial link before clearing the streaming bit and reopen it after setting that bit again. All state is held in ordinary flops, so the input clock may be stopped during standby and restarted later.

Top module: `sensor_stream_ctrl`

## Requirements
- R1: While reset is asserted, and until the first write after reset, readout_en is 0, standby is 1, ser_dis is 0 and row_idx and col_idx are 0.
- R2: The control word is at address 0, and its streaming bit is bit 2. Suppose a write sets that bit while the block is in standby, and call the clock edge that captures the write edge E. Then readout_en rises to 1 and standby falls to 0 on the edge after E.
- R3: Address 1 holds the column count C and address 2 holds the row count R. row_end pulses for one cycle every C streaming cycles. frame_end pulses together with the row_end of row R-1, once every C*R cycles.
- R4: Control bit 4 is the boundary select. With bit 4 at 0, clearing the streaming bit keeps readout running until the next frame_end. readout_en falls and standby rises on the edge after that strobe.
- R5: With bit 4 at 1, clearing the streaming bit stops readout on the edge after the next row_end, even partway through a frame.
- R6: If the streaming bit is set again before the selected boundary arrives, the stop request is cancelled and readout_en never drops.
- R7: In the first cycle of readout_en after standby, row_idx and col_idx are both 0.
- R8: The column and row counts written before standby still govern the frame timing after streaming resumes.
- R9: ser_dis equals control bit 12 as last written, whatever the streaming state.
- R10: A write to address 3 changes no register and has no visible effect.
- R11: After the clock is stopped during standby and then restarted, a streaming write resumes readout with correct frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (may be stopped while in standby) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 columns, 2 rows |
| wr_data_i | input | 16 | Register write data |
| readout_en_o | output | 1 | Readout engine enable |
| standby_o | output | 1 | Standby status flag |
| ser_dis_o | output | 1 | Serial interface disable |
| row_end_o | output | 1 | One-cycle end-of-row strobe |
| frame_end_o | output | 1 | One-cycle end-of-frame strobe |
| row_idx_o | output | 12 | Current readout row |
| col_idx_o | output | 12 | Current readout column |

## Verification
The stop request is issued at the start of row 0 in frame mode, and the bench expects readout to continue past two row ends and stop only after frame_end. The same request issued at the start of row 1 in row mode must stop readout after that row's end, which shows whether the mode bit really selects the boundary. A clear followed at once by a set of the streaming bit separates a correct cancel from a spurious stop. The frame period is measured again after a write to the unmapped address, after each standby and after a clock gap, to detect lost dimensions or a readout that resumes mid-frame.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // control word bit positions
  localparam int unsigned BIT_STREAM  = 2;
  localparam int unsigned BIT_ROWMODE = 4;
  localparam int unsigned BIT_SERDIS  = 12;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COLS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ROWS = 2'd2;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_STREAM  = 2'd1,
    ST_PENDING = 2'd2
  } run_state_e;

  typedef struct packed {
    logic ser_off;
    logic row_mode;
    logic stream;
  } ctrl_t;
endpackage

// File: rtl/ssc_regs.sv
module ssc_regs
  import ssc_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned DEF_COLS = 8,
  parameter int unsigned DEF_ROWS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cols_o,
  output logic [CNT_W-1:0]  rows_o
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cols_q, cols_d, rows_q, rows_d;
  logic             ctrl_we, cols_we, rows_we;

  generate
    if (DATA_W > CNT_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:CNT_W];
    end
  endgenerate

  always_comb begin
    ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);
    cols_we = wr_en_i && (wr_addr_i == ADDR_COLS);
    rows_we = wr_en_i && (wr_addr_i == ADDR_ROWS);
    ctrl_d.ser_off  = wr_data_i[BIT_SERDIS];
    ctrl_d.row_mode = wr_data_i[BIT_ROWMODE];
    ctrl_d.stream   = wr_data_i[BIT_STREAM];
    cols_d = wr_data_i[CNT_W-1:0];
    rows_d = wr_data_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cols_q <= CNT_W'(DEF_COLS);
      rows_q <= CNT_W'(DEF_ROWS);
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (cols_we) cols_q <= cols_d;
      if (rows_we) rows_q <= rows_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cols_o = cols_q;
  assign rows_o = rows_q;

  // R9
  ser_bit_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_CTRL) |=> (ctrl_o.ser_off == $past(wr_data_i[BIT_SERDIS])));

  // R10
  spare_addr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> ($stable(ctrl_o) && $stable(cols_o) && $stable(rows_o)));

  // R8
  dims_retained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(cols_o) && $stable(rows_o)));

endmodule

// File: rtl/ssc_readout_cnt.sv
module ssc_readout_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cols_i,
  input  logic [CNT_W-1:0] rows_i,
  output logic             row_end_o,
  output logic             frame_end_o,
  output logic [CNT_W-1:0] row_o,
  output logic [CNT_W-1:0] col_o
);

  logic [CNT_W-1:0] col_q, col_d, row_q, row_d;
  logic [CNT_W-1:0] col_lim, row_lim;
  logic             row_end, frame_end, cnt_en;

  always_comb begin
    col_lim   = (cols_i == '0) ? '0 : cols_i - CNT_W'(1);
    row_lim   = (rows_i == '0) ? '0 : rows_i - CNT_W'(1);
    row_end   = run_i && (col_q >= col_lim);
    frame_end = row_end && (row_q >= row_lim);
    cnt_en    = run_i || (col_q != '0) || (row_q != '0);
    col_d     = col_q + CNT_W'(1);
    row_d     = row_q;
    if (!run_i) begin
      col_d = '0;
      row_d = '0;
    end else if (row_end) begin
      col_d = '0;
      row_d = frame_end ? '0 : row_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (cnt_en) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign row_end_o   = row_end;
  assign frame_end_o = frame_end;
  assign row_o       = row_q;
  assign col_o       = col_q;

  // R3
  frame_on_row_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> row_end_o);

  // R7
  fresh_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (row_o == '0 && col_o == '0));

endmodule

// File: rtl/ssc_mode_fsm.sv
module ssc_mode_fsm
  import ssc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stream_i,
  input  logic row_mode_i,
  input  logic row_end_i,
  input  logic frame_end_i,
  output logic readout_en_o,
  output logic standby_o
);

  run_state_e state_q, state_d;
  logic       boundary;

  always_comb begin
    boundary = row_mode_i ? row_end_i : frame_end_i;
    state_d  = state_q;
    unique case (state_q)
      ST_STANDBY: if (stream_i) state_d = ST_STREAM;
      ST_STREAM:  if (!stream_i) state_d = ST_PENDING;
      ST_PENDING: begin
        if (stream_i)      state_d = ST_STREAM;
        else if (boundary) state_d = ST_STANDBY;
      end
      default:    state_d = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STANDBY;
    else         state_q <= state_d;
  end

  assign readout_en_o = (state_q != ST_STANDBY);
  assign standby_o    = (state_q == ST_STANDBY);

  // R4 R5
  stop_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(readout_en_o) |-> $past(row_mode_i ? row_end_i : frame_end_i));

  // R6
  cancel_keeps_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PENDING && stream_i) |=> readout_en_o);

  // R2
  resume_next_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && stream_i) |=> (readout_en_o && !standby_o));

  // R4
  frame_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PENDING && !row_mode_i && !frame_end_i) |=> readout_en_o);

endmodule

// File: rtl/sensor_stream_ctrl.sv
module sensor_stream_ctrl
  import ssc_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned DEF_COLS = 8,
  parameter int unsigned DEF_ROWS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              readout_en_o,
  output logic              standby_o,
  output logic              ser_dis_o,
  output logic              row_end_o,
  output logic              frame_end_o,
  output logic [CNT_W-1:0]  row_idx_o,
  output logic [CNT_W-1:0]  col_idx_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cols, rows;
  logic             run, row_end, frame_end;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ssc_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_COLS(DEF_COLS), .DEF_ROWS(DEF_ROWS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_s), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl), .cols_o(cols), .rows_o(rows)
  );

  ssc_readout_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n_s), .run_i(run), .cols_i(cols), .rows_i(rows),
    .row_end_o(row_end), .frame_end_o(frame_end), .row_o(row_idx_o), .col_o(col_idx_o)
  );

  ssc_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_n_s), .stream_i(ctrl.stream), .row_mode_i(ctrl.row_mode),
    .row_end_i(row_end), .frame_end_i(frame_end), .readout_en_o(run), .standby_o(standby_o)
  );

  assign readout_en_o = run;
  assign ser_dis_o    = ctrl.ser_off;
  assign row_end_o    = row_end;
  assign frame_end_o  = frame_end;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_n_s |=> (!readout_en_o && standby_o && !ser_dis_o));

endmodule

// File: tb/tb_sensor_stream_ctrl.sv
module tb_sensor_stream_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = 12;
  localparam int DW = 16;
  localparam int SIG_EN = 0, SIG_SB = 1, SIG_SER = 2, SIG_ROW = 3, SIG_COL = 4, SIG_VAL = 5;

  logic          clk = 1'b0;
  logic          clk_on = 1'b1;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic          readout_en, standby, ser_dis, row_end, frame_end;
  logic [CW-1:0] row_idx, col_idx;

  sensor_stream_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .readout_en_o(readout_en), .standby_o(standby), .ser_dis_o(ser_dis),
    .row_end_o(row_end), .frame_end_o(frame_end), .row_idx_o(row_idx), .col_idx_o(col_idx)
  );

  always begin
    #4;
    if (clk_on) clk = ~clk;
  end

  typedef struct {
    string req;
    int    sig;
    int    exp;
    int    act;
  } item_t;

  item_t sb_q[$];
  event  push_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  task automatic expect_sig(input string req, input int sig, input int exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp; it.act = 0;
    sb_q.push_back(it);
    -> push_ev;
  endtask

  task automatic expect_val(input string req, input int act, input int exp);
    item_t it;
    it.req = req; it.sig = SIG_VAL; it.exp = exp; it.act = act;
    sb_q.push_back(it);
    -> push_ev;
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(push_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        int    act;
        it = sb_q.pop_front();
        case (it.sig)
          SIG_EN:  act = int'(readout_en);
          SIG_SB:  act = int'(standby);
          SIG_SER: act = int'(ser_dis);
          SIG_ROW: act = int'(row_idx);
          SIG_COL: act = int'(col_idx);
          default: act = it.act;
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s actual %0d expected %0d", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_pos(input int r, input int c);
    for (int i = 0; i < 300; i++) begin
      if (readout_en && int'(row_idx) == r && int'(col_idx) == c) break;
      @(negedge clk);
    end
  endtask

  // cycles from one strobe to the next
  task automatic gap(input bit use_frame, output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      if (use_frame ? frame_end : row_end) break;
      @(negedge clk);
    end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (use_frame ? frame_end : row_end) break;
    end
  endtask

  // runs until readout_en drops, remembering the strobes of the last enabled cycle
  task automatic stop_run(output bit lf, output bit lr, output int lrow);
    lf = 0; lr = 0; lrow = -1;
    for (int i = 0; i < 300; i++) begin
      if (!readout_en) break;
      lf = frame_end; lr = row_end; lrow = int'(row_idx);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit lf, lr;
    int lrow;
    int drops;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tick(3);
    // R1 reset state
    expect_sig("R1 readout_en", SIG_EN, 0);
    expect_sig("R1 standby", SIG_SB, 1);
    expect_sig("R1 ser_dis", SIG_SER, 0);
    expect_sig("R1 row_idx", SIG_ROW, 0);
    expect_sig("R1 col_idx", SIG_COL, 0);
    rst_n = 1'b1;
    tick(4);
    expect_sig("R1 standby after release", SIG_SB, 1);

    wr(2'd1, 16'd4);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0004);
    expect_sig("R2 not yet enabled at capture edge", SIG_EN, 0);
    tick(1);
    expect_sig("R2 readout_en rises", SIG_EN, 1);
    expect_sig("R2 standby falls", SIG_SB, 0);
    expect_sig("R7 start row", SIG_ROW, 0);
    expect_sig("R7 start col", SIG_COL, 0);

    gap(1'b0, n);
    expect_val("R3 row period", n, 4);
    gap(1'b1, n);
    expect_val("R3 frame period", n, 12);
    expect_sig("R3 frame_end on last row", SIG_ROW, 2);
    expect_val("R3 row_end with frame_end", int'(row_end), 1);
    tick(1);
    expect_val("R3 frame_end single cycle", int'(frame_end), 0);

    // R4 frame-boundary stop
    wait_pos(0, 0);
    wr(2'd0, 16'h0000);
    stop_run(lf, lr, lrow);
    expect_val("R4 stopped after frame_end", int'(lf), 1);
    expect_val("R4 last row", lrow, 2);
    expect_sig("R4 standby set", SIG_SB, 1);

    // R10 unmapped write in standby
    wr(2'd3, 16'hFFFF);
    tick(2);
    expect_sig("R10 spare write leaves standby", SIG_SB, 1);
    expect_sig("R10 spare write leaves ser_dis", SIG_SER, 0);

    wr(2'd0, 16'h0014);
    tick(1);
    expect_sig("R7 resume row", SIG_ROW, 0);
    expect_sig("R7 resume col", SIG_COL, 0);
    gap(1'b1, n);
    expect_val("R8 frame period kept", n, 12);
    gap(1'b0, n);
    expect_val("R10 row period untouched", n, 4);

    // R5 row-boundary stop
    wait_pos(1, 0);
    wr(2'd0, 16'h0010);
    stop_run(lf, lr, lrow);
    expect_val("R5 stopped after row_end", int'(lr), 1);
    expect_val("R5 stopped row", lrow, 1);
    expect_val("R5 not a frame end", int'(lf), 0);
    expect_sig("R5 standby set", SIG_SB, 1);

    // R6 cancel
    wr(2'd0, 16'h0004);
    tick(1);
    expect_sig("R7 resume row after row stop", SIG_ROW, 0);
    wait_pos(0, 0);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0004);
    drops = 0;
    for (int i = 0; i < 40; i++) begin
      if (!readout_en) drops++;
      @(negedge clk);
    end
    expect_val("R6 no interruption", drops, 0);

    // R9 serial disable sequencing
    wr(2'd0, 16'h1004);
    expect_sig("R9 ser_dis set while streaming", SIG_SER, 1);
    wr(2'd0, 16'h1000);
    stop_run(lf, lr, lrow);
    expect_sig("R9 ser_dis held in standby", SIG_SER, 1);
    expect_val("R4 frame stop with serial off", int'(lf), 1);

    // R11 clock gap during standby
    clk_on = 1'b0;
    #2000;
    clk_on = 1'b1;
    tick(2);
    wr(2'd0, 16'h1004);
    tick(1);
    expect_sig("R11 resumes after clock gap", SIG_EN, 1);
    expect_sig("R11 row after gap", SIG_ROW, 0);
    expect_sig("R9 ser_dis still set", SIG_SER, 1);
    wr(2'd0, 16'h0004);
    expect_sig("R9 ser_dis cleared", SIG_SER, 0);
    gap(1'b1, n);
    expect_val("R11 frame period after gap", n, 12);

    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule